// File: doc/BRIEF.md
# Serial Link Training and Rate Negotiation Controller

This block is an abstracted training state machine for one end of a serial point-to-point link. From reset it waits for a receiver to be detected, then exchanges training ordered sets through a polling phase and a configuration phase until the link is operational at the base rate. Once the link is operational it steps the data rate upward through recovery passes until the top rate is reached. The physical layer is reduced to single-cycle event inputs, so the block can be dropped into a link model or a fast simulation environment.

Three rate-raising paths are offered. The stepwise path climbs 8, 16 and 32 GT/s and equalizes at each step. The bypass path jumps from the base rate straight to the top rate and equalizes only there; if the link then reports a reliability error, the path falls back to stepwise equalization from 8 GT/s. The stored-settings path jumps to the top rate and runs no equalization at all. Equalization runs as a short phase sequence whose length depends on the port role and on whether the first phase already gave a good result. Ordered-set thresholds and the per-state timeout are parameters, so they can be scaled down.

Top module: `link_train_ctrl`

## Requirements
- R1: While rst_n is low the outputs are state_o = 0 (Detect), rate_o = 0, link_up_o = 0, eq_active_o = 0 and eq_phase_o = 0. State codes are Detect 0, Polling 1, Configuration 2, Operational 3, Recovery 4, Equalization 5.
- R2: In Detect the machine moves to Polling on the first clock edge that samples rx_detect high, and stays in Detect otherwise.
- R3: Polling, Configuration, Recovery and Equalization each last at most TIMEOUT_CYC cycles; the counter restarts on every state change, and when it expires the next state is Detect with rate_o = 0.
- R4: Polling moves to Configuration only after at least POLL_TX cycles with ts_sent high and at least POLL_RX cycles with ts_rcvd high since Polling was entered.
- R5: Configuration moves to Operational only when CFG_TX sent and CFG_RX received ordered sets have been counted and cfg_match is high; the first Operational state after Configuration always has rate_o = 0.
- R6: Rate codes are 0 = 2.5, 1 = 5, 2 = 8, 3 = 16, 4 = 32 GT/s. With speed_mode = 0 (or 3) the Operational rates visited are 0, 2, 3, 4, each raise going through Recovery and then Equalization; rate_o changes only on leaving Recovery or on return to Detect.
- R7: With speed_mode = 1 the Operational rates visited are 0 then 4, with exactly one Equalization, at rate 4.
- R8: With speed_mode = 2 the Operational rates visited are 0 then 4 and Equalization is never entered.
- R9: An equalization pass starts at phase 1 for a downstream port (upstream_port = 0) and at phase 0 for an upstream port, advances one phase per eq_phase_done pulse and ends after phase 3.
- R10: A downstream port whose eq_p1_ok is high when phase 1 completes ends the pass at that point, skipping phases 2 and 3; an upstream port ignores eq_p1_ok.
- R11: A rel_err pulse while Operational at rate 4 reached by the bypass path causes Operational visits at rates 2, 3 and 4, each preceded by Equalization; rel_err has no effect in the other paths or after such a fallback.
- R12: link_up_o is high exactly while the state is Operational.
- R13: sync_clr high on a clock edge forces Detect with rate_o = 0 on that edge, from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| sync_clr | input | 1 | Synchronous return to Detect |
| rx_detect | input | 1 | Far-end receiver detected |
| ts_sent | input | 1 | One training ordered set sent this cycle |
| ts_rcvd | input | 1 | One training ordered set received this cycle |
| cfg_match | input | 1 | Link parameters agreed by both ends |
| eq_phase_done | input | 1 | Current equalization phase completed |
| eq_p1_ok | input | 1 | Phase 1 result is good enough to stop |
| upstream_port | input | 1 | 1 = upstream port role, 0 = downstream |
| speed_mode | input | 2 | 0/3 stepwise, 1 bypass, 2 stored settings |
| rel_err | input | 1 | Link reliability problem reported |
| state_o | output | 3 | Current training state code |
| rate_o | output | 3 | Current rate code |
| eq_active_o | output | 1 | Equalization in progress |
| eq_phase_o | output | 2 | Current equalization phase (0 when idle) |
| link_up_o | output | 1 | Link operational |

## Verification
The bench builds the controller with ordered-set thresholds of 4/3 in Polling, 2/3 in Configuration, 2/2 in Recovery and a 40-cycle timeout. These small values make the exact expiry edge of a state and the one-short threshold boundary reachable in a few dozen cycles each. They also keep a full sweep cheap: every rate path, both port roles and both phase-1 outcomes, including the reliability fallback. Expected rate visit lists and phase sequences are derived arithmetically from the mode, the role and the phase-1 flag.

// File: rtl/lt_pkg.sv
package lt_pkg;

  typedef enum logic [2:0] {
    ST_DETECT = 3'd0,
    ST_POLL   = 3'd1,
    ST_CFG    = 3'd2,
    ST_L0     = 3'd3,
    ST_RECOV  = 3'd4,
    ST_EQ     = 3'd5
  } lt_state_e;

  localparam logic [2:0] RATE_2G5 = 3'd0;
  localparam logic [2:0] RATE_8G  = 3'd2;
  localparam logic [2:0] RATE_16G = 3'd3;
  localparam logic [2:0] RATE_32G = 3'd4;

  localparam logic [1:0] MODE_STEP   = 2'd0;
  localparam logic [1:0] MODE_BYPASS = 2'd1;
  localparam logic [1:0] MODE_NOEQ   = 2'd2;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // next rate in the stepwise climb
  function automatic logic [2:0] step_rate(input logic [2:0] cur);
    logic [2:0] r;
    case (cur)
      RATE_2G5: r = RATE_8G;
      RATE_8G:  r = RATE_16G;
      default:  r = RATE_32G;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/lt_os_counter.sv
module lt_os_counter #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          pulse,
  input  logic [CW-1:0] target,
  output logic          met
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign met = (cnt_q >= target);

  always_comb begin
    cnt_en = clr | (pulse & ~met);
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  AST_OS_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(met) && !$past(clr)) |-> met) else $error("ordered-set count dropped"); // R4

endmodule

// File: rtl/lt_timeout.sv
module lt_timeout #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reload,
  input  logic run,
  output logic expired
);

  localparam int TW = $clog2(LIMIT + 1);
  localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en  = reload | run;
    cnt_d   = reload ? '0 : cnt_q + 1'b1;
    expired = run & (cnt_q == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  AST_TMO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= LAST)) else $error("timeout counter ran past limit"); // R3

endmodule

// File: rtl/lt_eq_seq.sv
module lt_eq_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       active,
  input  logic       upstream,
  input  logic       p1_ok,
  input  logic       phase_done,
  output logic [1:0] phase_o,
  output logic       finish_o
);

  logic [1:0] phase_q;
  logic [1:0] phase_d;
  logic       phase_en;
  logic       last_phase;

  always_comb begin
    last_phase = (phase_q == 2'd3) || ((phase_q == 2'd1) && !upstream && p1_ok);
    finish_o   = active & phase_done & last_phase;
    phase_en   = start | (active & phase_done & ~last_phase);
    phase_d    = start ? (upstream ? 2'd0 : 2'd1) : phase_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 2'd0;
    end else if (phase_en) begin
      phase_q <= phase_d;
    end
  end

  assign phase_o = phase_q;

  AST_EQ_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && (phase_q != $past(phase_q))) |-> (phase_q == 2'($past(phase_q) + 2'd1)))
    else $error("equalization phase skipped"); // R9

  AST_EQ_FIRST_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> (phase_q == ($past(upstream) ? 2'd0 : 2'd1)))
    else $error("equalization started at wrong phase"); // R9

  AST_EQ_EARLY_END: assert property (@(posedge clk) disable iff (!rst_n)
    (finish_o && phase_q != 2'd3) |-> (!upstream && p1_ok && phase_q == 2'd1))
    else $error("equalization ended early without cause"); // R10

endmodule

// File: rtl/link_train_ctrl.sv
module link_train_ctrl #(
  parameter int POLL_TX     = 1024,
  parameter int POLL_RX     = 8,
  parameter int CFG_TX      = 16,
  parameter int CFG_RX      = 8,
  parameter int RCV_TX      = 16,
  parameter int RCV_RX      = 8,
  parameter int TIMEOUT_CYC = 24000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_clr,
  input  logic       rx_detect,
  input  logic       ts_sent,
  input  logic       ts_rcvd,
  input  logic       cfg_match,
  input  logic       eq_phase_done,
  input  logic       eq_p1_ok,
  input  logic       upstream_port,
  input  logic [1:0] speed_mode,
  input  logic       rel_err,
  output logic [2:0] state_o,
  output logic [2:0] rate_o,
  output logic       eq_active_o,
  output logic [1:0] eq_phase_o,
  output logic       link_up_o
);
  import lt_pkg::*;

  localparam int OS_MAX = imax(imax(imax(POLL_TX, POLL_RX), imax(CFG_TX, CFG_RX)), imax(RCV_TX, RCV_RX));
  localparam int OS_CW  = $clog2(OS_MAX + 1);
  localparam int N_CH   = 2; // channel 0 = sent, channel 1 = received

  lt_state_e  state_q, state_d;
  logic [2:0] rate_q, rate_d;
  logic [2:0] tgt_q, tgt_d;
  logic       fb_q, fb_d;
  logic       eqn_q, eqn_d;
  logic [1:0] mode_eff;

  logic             chg;
  logic             timed;
  logic             tmo_exp;
  logic [N_CH-1:0]  os_pulse;
  logic [N_CH-1:0]  os_met;
  logic             os_all;
  logic [OS_CW-1:0] os_tgt [N_CH];
  logic             eq_start;
  logic             eq_finish;
  logic [1:0]       eq_phase;

  // ---------------- ordered-set thresholds per state ----------------
  always_comb begin
    case (state_q)
      ST_POLL:  begin os_tgt[0] = OS_CW'(POLL_TX); os_tgt[1] = OS_CW'(POLL_RX); end
      ST_CFG:   begin os_tgt[0] = OS_CW'(CFG_TX);  os_tgt[1] = OS_CW'(CFG_RX);  end
      ST_RECOV: begin os_tgt[0] = OS_CW'(RCV_TX);  os_tgt[1] = OS_CW'(RCV_RX);  end
      default:  begin os_tgt[0] = '1;              os_tgt[1] = '1;              end
    endcase
  end

  assign os_pulse = {ts_rcvd, ts_sent};
  assign chg      = (state_d != state_q);
  assign os_all   = &os_met;

  for (genvar g = 0; g < N_CH; g++) begin : g_os
    lt_os_counter #(.CW(OS_CW)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (chg),
      .pulse  (os_pulse[g]),
      .target (os_tgt[g]),
      .met    (os_met[g])
    );
  end

  // ---------------- state timeout ----------------
  assign timed = (state_q == ST_POLL) || (state_q == ST_CFG) ||
                 (state_q == ST_RECOV) || (state_q == ST_EQ);

  lt_timeout #(.LIMIT(TIMEOUT_CYC)) u_tmo (
    .clk     (clk),
    .rst_n   (rst_n),
    .reload  (chg),
    .run     (timed),
    .expired (tmo_exp)
  );

  // ---------------- equalization phases ----------------
  assign eq_start = (state_d == ST_EQ) && (state_q != ST_EQ);

  lt_eq_seq u_eq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (eq_start),
    .active     (state_q == ST_EQ),
    .upstream   (upstream_port),
    .p1_ok      (eq_p1_ok),
    .phase_done (eq_phase_done),
    .phase_o    (eq_phase),
    .finish_o   (eq_finish)
  );

  // ---------------- next-state logic ----------------
  always_comb begin
    if (fb_q) begin
      mode_eff = MODE_STEP;
    end else if ((speed_mode == MODE_BYPASS) || (speed_mode == MODE_NOEQ)) begin
      mode_eff = speed_mode;
    end else begin
      mode_eff = MODE_STEP;
    end
  end

  always_comb begin
    state_d = state_q;
    rate_d  = rate_q;
    tgt_d   = tgt_q;
    fb_d    = fb_q;
    eqn_d   = eqn_q;
    case (state_q)
      ST_DETECT: begin
        if (rx_detect) state_d = ST_POLL;
      end
      ST_POLL: begin
        if (tmo_exp)     state_d = ST_DETECT;
        else if (os_all) state_d = ST_CFG;
      end
      ST_CFG: begin
        if (tmo_exp)                   state_d = ST_DETECT;
        else if (os_all && cfg_match)  state_d = ST_L0;
      end
      ST_L0: begin
        if (rate_q != RATE_32G) begin
          state_d = ST_RECOV;
          tgt_d   = (mode_eff == MODE_STEP) ? step_rate(rate_q) : RATE_32G;
          eqn_d   = (mode_eff != MODE_NOEQ);
        end else if (rel_err && (mode_eff == MODE_BYPASS)) begin
          state_d = ST_RECOV;
          tgt_d   = RATE_8G;
          eqn_d   = 1'b1;
          fb_d    = 1'b1;
        end
      end
      ST_RECOV: begin
        if (tmo_exp) begin
          state_d = ST_DETECT;
        end else if (os_all) begin
          rate_d  = tgt_q;
          state_d = eqn_q ? ST_EQ : ST_L0;
        end
      end
      ST_EQ: begin
        if (tmo_exp)        state_d = ST_DETECT;
        else if (eq_finish) state_d = ST_L0;
      end
      default: state_d = ST_DETECT;
    endcase
    if (sync_clr) state_d = ST_DETECT;
    if (state_d == ST_DETECT) begin
      rate_d = RATE_2G5;
      fb_d   = 1'b0;
    end
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_DETECT;
      rate_q  <= RATE_2G5;
      tgt_q   <= RATE_2G5;
      fb_q    <= 1'b0;
      eqn_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rate_q  <= rate_d;
      tgt_q   <= tgt_d;
      fb_q    <= fb_d;
      eqn_q   <= eqn_d;
    end
  end

  assign state_o     = state_q;
  assign rate_o      = rate_q;
  assign eq_active_o = (state_q == ST_EQ);
  assign eq_phase_o  = eq_active_o ? eq_phase : 2'd0;
  assign link_up_o   = (state_q == ST_L0);

  // ---------------- assertions ----------------
  AST_TMO_TO_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_exp |=> (state_q == ST_DETECT && rate_q == RATE_2G5)) else $error("timeout did not return to Detect"); // R3

  AST_CFG_NEEDS_OS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CFG && $past(state_q) == ST_POLL) |-> $past(os_all)) else $error("left Polling early"); // R4

  AST_FIRST_L0_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_L0 && $past(state_q) == ST_CFG) |-> (rate_q == RATE_2G5)) else $error("first L0 not at base rate"); // R5

  AST_RATE_IN_RECOV: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_q != $past(rate_q)) |-> ($past(state_q) == ST_RECOV || rate_q == RATE_2G5)) else $error("rate changed outside Recovery"); // R6

  AST_LINKUP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_up_o) |-> ($past(state_q) == ST_CFG || $past(state_q) == ST_RECOV || $past(state_q) == ST_EQ))
    else $error("link up from wrong state"); // R12

  AST_SYNC_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    sync_clr |=> (state_q == ST_DETECT && rate_q == RATE_2G5)) else $error("sync clear ignored"); // R13

endmodule

// File: tb/link_train_ctrl_bench.sv
`timescale 1ns/1ps
module link_train_ctrl_bench;

  localparam int P_TX = 4, P_RX = 3, C_TX = 2, C_RX = 3, V_TX = 2, V_RX = 2, TMO = 40;

  logic clk = 1'b0;
  logic rst_n;
  logic sync_clr, rx_detect, cfg_match, eq_p1_ok, upstream_port, rel_err;
  logic [1:0] speed_mode;
  logic man_tx, man_rx, man_eqd;
  logic auto_en;
  logic auto_ts, auto_eqd;
  logic ts_sent, ts_rcvd, eq_phase_done;
  logic [2:0] state_o, rate_o;
  logic eq_active_o, link_up_o;
  logic [1:0] eq_phase_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  assign ts_sent       = auto_en ? auto_ts  : man_tx;
  assign ts_rcvd       = auto_en ? auto_ts  : man_rx;
  assign eq_phase_done = auto_en ? auto_eqd : man_eqd;

  link_train_ctrl #(
    .POLL_TX(P_TX), .POLL_RX(P_RX), .CFG_TX(C_TX), .CFG_RX(C_RX),
    .RCV_TX(V_TX), .RCV_RX(V_RX), .TIMEOUT_CYC(TMO)
  ) u_link_train_ctrl (
    .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .rx_detect(rx_detect),
    .ts_sent(ts_sent), .ts_rcvd(ts_rcvd), .cfg_match(cfg_match),
    .eq_phase_done(eq_phase_done), .eq_p1_ok(eq_p1_ok), .upstream_port(upstream_port),
    .speed_mode(speed_mode), .rel_err(rel_err), .state_o(state_o), .rate_o(rate_o),
    .eq_active_o(eq_active_o), .eq_phase_o(eq_phase_o), .link_up_o(link_up_o)
  );

  // reactive link partner: ordered sets every cycle in training states, phase-done every other cycle
  always @(negedge clk) begin
    auto_ts  <= auto_en && (state_o == 3'd1 || state_o == 3'd2 || state_o == 3'd4);
    auto_eqd <= auto_en && eq_active_o && !auto_eqd;
  end

  // port monitor, sampling 1 ns after the active edge
  logic mon_clr;
  int rate_log [16];
  int ph_log [64];
  int n_rate, n_ph;
  int prev_st;
  bit prev_act;
  int prev_ph;
  always @(posedge clk) begin
    #1;
    if (mon_clr) begin
      n_rate = 0;
      n_ph   = 0;
    end else begin
      if (state_o == 3'd3 && prev_st != 3 && n_rate < 16) begin
        rate_log[n_rate] = int'(rate_o);
        n_rate++;
      end
      if (eq_active_o && (!prev_act || int'(eq_phase_o) != prev_ph) && n_ph < 64) begin
        ph_log[n_ph] = int'(eq_phase_o);
        n_ph++;
      end
    end
    prev_st  = int'(state_o);
    prev_act = eq_active_o;
    prev_ph  = int'(eq_phase_o);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic clear_all();
    @(negedge clk);
    auto_en = 0; rx_detect = 0; rel_err = 0; man_tx = 0; man_rx = 0; man_eqd = 0;
    sync_clr = 1; mon_clr = 1;
    @(negedge clk);
    sync_clr = 0;
    @(negedge clk);
    mon_clr = 0;
  endtask

  task automatic pulse_os(input bit tx, input bit rx);
    @(negedge clk); man_tx = tx; man_rx = rx;
    @(negedge clk); man_tx = 0; man_rx = 0;
  endtask

  task automatic wait_top();
    for (int i = 0; i < 3000; i++) begin
      if (state_o == 3'd3 && rate_o == 3'd4) break;
      @(negedge clk);
    end
  endtask

  function automatic int per_eq(input bit up, input bit sat);
    if (up) return 4;
    return sat ? 1 : 3;
  endfunction

  // check that the phase log is n_eq back-to-back passes of the expected shape
  task automatic chk_phases(input string req, input int n_eq, input bit up, input bit sat);
    int np;
    int st;
    int bad;
    np  = per_eq(up, sat);
    st  = up ? 0 : 1;
    bad = 0;
    chk(n_ph == n_eq * np, req, n_ph, n_eq * np);
    for (int i = 0; i < n_ph; i++) begin
      if (ph_log[i] != st + (i % np)) bad++;
    end
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic run_cfg(input int mode, input bit up, input bit sat);
    int exp_r [8];
    int n_exp;
    int bad;
    string rq;
    clear_all();
    speed_mode = 2'(mode); upstream_port = up; eq_p1_ok = sat; cfg_match = 1;
    auto_en = 1; rx_detect = 1;
    wait_top();
    repeat (5) @(negedge clk);
    if (mode == 1) begin
      exp_r[0] = 0; exp_r[1] = 4; n_exp = 2; rq = "R7";
    end else if (mode == 2) begin
      exp_r[0] = 0; exp_r[1] = 4; n_exp = 2; rq = "R8";
    end else begin
      exp_r[0] = 0; exp_r[1] = 2; exp_r[2] = 3; exp_r[3] = 4; n_exp = 4; rq = "R6";
    end
    chk(n_rate == n_exp, rq, n_rate, n_exp);
    bad = 0;
    for (int i = 0; i < n_exp && i < n_rate; i++) if (rate_log[i] != exp_r[i]) bad++;
    chk(bad == 0, rq, bad, 0);
    chk(link_up_o == 1'b1 && state_o == 3'd3, "R12", int'(link_up_o), 1);
    if (mode == 2) chk(n_ph == 0, "R8", n_ph, 0);
    else chk_phases(sat && !up ? "R10" : "R9", (mode == 1) ? 1 : 3, up, sat);
    // reliability error
    @(negedge clk); rel_err = 1;
    @(negedge clk); rel_err = 0;
    repeat (5) @(negedge clk);
    wait_top();
    repeat (5) @(negedge clk);
    if (mode == 1) begin
      chk(n_rate == 5, "R11", n_rate, 5);
      bad = 0;
      if (n_rate == 5) begin
        if (rate_log[2] != 2) bad++;
        if (rate_log[3] != 3) bad++;
        if (rate_log[4] != 4) bad++;
      end
      chk(bad == 0, "R11", bad, 0);
      chk_phases("R11", 4, up, sat);
      @(negedge clk); rel_err = 1;
      @(negedge clk); rel_err = 0;
      repeat (10) @(negedge clk);
      chk(n_rate == 5 && state_o == 3'd3, "R11", n_rate, 5);
    end else begin
      chk(n_rate == n_exp && state_o == 3'd3 && rate_o == 3'd4, "R11", n_rate, n_exp);
    end
  endtask

  initial begin
    #(100000 * 5);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    rst_n = 0; sync_clr = 0; rx_detect = 0; cfg_match = 0; eq_p1_ok = 0;
    upstream_port = 0; rel_err = 0; speed_mode = 2'd2;
    man_tx = 0; man_rx = 0; man_eqd = 0; auto_en = 0; mon_clr = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(state_o == 3'd0, "R1", int'(state_o), 0);
    chk(rate_o == 3'd0 && link_up_o == 0, "R1", int'(rate_o), 0);
    chk(eq_active_o == 0 && eq_phase_o == 0, "R1", int'(eq_phase_o), 0);
    rst_n = 1;
    @(negedge clk); mon_clr = 0;
    repeat (3) @(negedge clk);
    chk(state_o == 3'd0, "R2", int'(state_o), 0);

    // R3 exact timeout edge in Polling
    rx_detect = 1;
    @(posedge clk);
    repeat (TMO - 1) @(posedge clk);
    @(negedge clk);
    chk(state_o == 3'd1, "R2", int'(state_o), 1);
    rx_detect = 0;
    @(posedge clk);
    @(negedge clk);
    chk(state_o == 3'd0, "R3", int'(state_o), 0);

    // R4 thresholds: sent count full, received one short
    @(negedge clk); rx_detect = 1;
    @(negedge clk); rx_detect = 0;
    for (int i = 0; i < P_TX; i++) pulse_os(1, 0);
    for (int i = 0; i < P_RX - 1; i++) pulse_os(0, 1);
    repeat (2) @(negedge clk);
    chk(state_o == 3'd1, "R4", int'(state_o), 1);
    pulse_os(0, 1);
    @(negedge clk);
    chk(state_o == 3'd2, "R4", int'(state_o), 2);

    // R5 configuration waits for cfg_match
    for (int i = 0; i < C_RX; i++) pulse_os(1, 1);
    repeat (2) @(negedge clk);
    chk(state_o == 3'd2, "R5", int'(state_o), 2);
    cfg_match = 1;
    @(negedge clk);
    chk(state_o == 3'd3 && rate_o == 3'd0, "R5", int'(state_o), 3);
    chk(link_up_o == 1'b1, "R12", int'(link_up_o), 1);
    @(negedge clk);
    chk(state_o == 3'd4 && link_up_o == 1'b0, "R12", int'(state_o), 4);
    // R3 timeout in Recovery, rate unchanged then back to base
    repeat (TMO + 2) @(negedge clk);
    chk(state_o == 3'd0 && rate_o == 3'd0, "R3", int'(state_o), 0);

    // sweep: path x role x phase-1 outcome
    for (int m = 0; m < 3; m++)
      for (int u = 0; u < 2; u++)
        for (int s = 0; s < 2; s++)
          run_cfg(m, u[0], s[0]);

    // R13 synchronous clear from operational top rate
    chk(state_o == 3'd3 && rate_o == 3'd4, "R13", int'(rate_o), 4);
    @(negedge clk); auto_en = 0; sync_clr = 1;
    @(negedge clk); sync_clr = 0;
    chk(state_o == 3'd0 && rate_o == 3'd0 && link_up_o == 0, "R13", int'(state_o), 0);

    finish_run();
  end

endmodule